// File: doc/BRIEF.md
# High-Speed UART Receive Buffer

This block sits between the receive shifter of a high-speed UART and the host. Each decoded character arrives on a one-cycle strobe together with a framing-error flag and a break flag. All three are stored in a 64-entry first-in first-out buffer. The host pulls characters through an 11-bit read word. It watches the fill count through a 16-bit level word, whose upper byte carries the transmit count supplied by the transmit side.

Two service requests leave the block. The first is a fill-threshold request, with the threshold picked by a 3-bit code. The second is an idle request: it fires when characters have been waiting for a programmed number of character times, measured in oversample ticks, with no new character and no read. A character that finds the buffer full is discarded and reported as a one-cycle overrun pulse. The three events are also presented at their fixed positions in a 7-bit request vector for the interrupt logic next door.

Top module: `hsu_rx_buffer`

## Requirements
- R1: The buffer holds up to 64 characters and returns them in arrival order. Bits 7:0 of `level_word` give the number stored, one cycle after each accepted write or read.
- R2: While the buffer holds data, `rd_word` shows the oldest entry as follows: character in bits 7:0, bit 8 = 0, framing-error flag in bit 9, break flag in bit 10.
- R3: While the buffer is empty, `rd_word` equals 0x100 (bit 8 set, all else zero). A read pulse in that state moves no pointer, and the next stored character is the next one read.
- R4: Bits 15:8 of `level_word` equal the `tx_level` input in the same cycle.
- R5: `trig_req` is high exactly while the stored count is at or above the threshold. The thresholds for `trig_code` 0..5 are 1, 4, 8, 16, 32 and 48; codes 6 and 7 behave as 48.
- R6: `tmo_code` 0 disables the idle request. Codes 1, 2 and 3 require 4, 8 and 16 idle character times. One character time is `char_ticks` pulses of `os_tick`, and a `char_ticks` of 0 counts as 1.
- R7: The idle timer restarts on every `wr_valid` and every `rd_en`. `tmo_req` is high only when the timer has expired, the buffer is non-empty and `trig_req` is low.
- R8: A write while the buffer is full and no read is popping is discarded, and `ovr_pulse` is high for exactly the following cycle. A write in the same cycle as a read of a full buffer is accepted.
- R9: `irq_vec` carries `trig_req` in bit 1, `tmo_req` in bit 2 and `ovr_pulse` in bit 5; every other bit is 0.
- R10: After reset the count is 0, `rd_word` is 0x100, and `trig_req`, `tmo_req`, `ovr_pulse` and `irq_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle strobe: a received character is presented |
| wr_char | input | 8 | Received character |
| wr_ferr | input | 1 | Framing error seen on that character |
| wr_brk | input | 1 | Break condition seen on that character |
| rd_en | input | 1 | Host read pulse; pops the oldest entry if one exists |
| rd_word | output | 11 | Read word: {break, frame error, empty, character} |
| tx_level | input | 8 | Transmit-side fill count, passed into the level word |
| level_word | output | 16 | {tx_level, receive count} |
| trig_code | input | 3 | Receive threshold select |
| tmo_code | input | 2 | Idle-timeout select |
| char_ticks | input | 16 | Oversample ticks per character time |
| os_tick | input | 1 | Oversample tick strobe |
| trig_req | output | 1 | Fill-threshold request |
| tmo_req | output | 1 | Idle-timeout request |
| ovr_pulse | output | 1 | One-cycle pulse for a discarded character |
| irq_vec | output | 7 | Requests at their interrupt bit positions |

## Verification
The bound checker watches several rules on every cycle:
- the count never exceeds 64, and it stays put on cycles with neither a write nor a read;
- the empty read word appears whenever the count is zero;
- an overrun pulse only follows a dropped write into a full buffer;
- the trigger request never appears while the buffer is empty, and the idle request never appears while it is empty or while the trigger request is high;
- the request vector matches the three request outputs.

Only the directed scenarios show the rest:
- arrival order and flag placement in the read word;
- the exact threshold for each trigger code;
- the cycle count to expiry for each timeout code and tick length;
- that a read restarts the timer;
- that a simultaneous read and write on a full buffer loses nothing.

// File: rtl/hsu_rx_pkg.sv
package hsu_rx_pkg;

    localparam int CHAR_W  = 8;
    localparam int WORD_W  = CHAR_W + 3;
    localparam int TMO_CW  = 5;
    localparam int IRQ_W   = 7;
    localparam int IRQ_TRIG = 1;
    localparam int IRQ_TMO  = 2;
    localparam int IRQ_OVR  = 5;

    localparam logic [WORD_W-1:0] EMPTY_WORD = 11'h100;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic [CHAR_W-1:0] ch;
    } rx_ent_t;

    // idle character times required per timeout code
    function automatic logic [TMO_CW-1:0] tmo_limit(input logic [1:0] code);
        case (code)
            2'd1:    tmo_limit = 5'd4;
            2'd2:    tmo_limit = 5'd8;
            2'd3:    tmo_limit = 5'd16;
            default: tmo_limit = 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/hsu_rx_store.sv
module hsu_rx_store
    import hsu_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  rx_ent_t       ent_in,
    input  logic          pop_req,
    output rx_ent_t       head,
    output logic [CW-1:0] count,
    output logic          ovr
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;
    rx_ent_t mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) bump = '0;
        else                     bump = p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_req && (st_q.cnt != '0);
        do_push = push_req && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) st_d.wp = bump(st_q.wp);
        if (do_pop)  st_d.rp = bump(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.ovr = push_req && !do_push;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= ent_in;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;
    assign ovr   = st_q.ovr;

endmodule

// File: rtl/hsu_rx_thresh.sv
module hsu_rx_thresh #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [2:0]    code,
    input  logic [CW-1:0] count,
    output logic          trig
);

    logic [CW-1:0] thr;

    always_comb begin
        case (code)
            3'd0:    thr = CW'(1);
            3'd1:    thr = CW'(4);
            3'd2:    thr = CW'(8);
            3'd3:    thr = CW'(16);
            3'd4:    thr = CW'(32);
            default: thr = CW'(48);
        endcase
        trig = (count >= thr);
    end

endmodule

// File: rtl/hsu_rx_idle_timer.sv
module hsu_rx_idle_timer
    import hsu_rx_pkg::*;
#(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              nonempty,
    input  logic              tick,
    input  logic [TICK_W-1:0] char_ticks,
    input  logic [1:0]        code,
    output logic              expired
);

    typedef struct packed {
        logic [TICK_W-1:0] tick_cnt;
        logic [TMO_CW-1:0] chars;
    } st_t;

    st_t st_d, st_q;
    logic [TMO_CW-1:0] limit;
    logic              char_done;

    always_comb begin
        st_d      = st_q;
        limit     = tmo_limit(code);
        char_done = ({1'b0, st_q.tick_cnt} + 1'b1) >= {1'b0, char_ticks};
        if (restart || !nonempty || limit == '0) begin
            st_d = '0;
        end else if (tick) begin
            if (char_done) begin
                st_d.tick_cnt = '0;
                if (st_q.chars < limit) st_d.chars = st_q.chars + 1'b1;
            end else begin
                st_d.tick_cnt = st_q.tick_cnt + 1'b1;
            end
        end
        expired = (limit != '0) && nonempty && (st_q.chars >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/hsu_rx_buffer.sv
module hsu_rx_buffer
    import hsu_rx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int TICK_W = 16,
    parameter int TXL_W  = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int RXL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [CHAR_W-1:0]     wr_char,
    input  logic                  wr_ferr,
    input  logic                  wr_brk,
    input  logic                  rd_en,
    output logic [WORD_W-1:0]     rd_word,
    input  logic [TXL_W-1:0]      tx_level,
    output logic [TXL_W+RXL_W-1:0] level_word,
    input  logic [2:0]            trig_code,
    input  logic [1:0]            tmo_code,
    input  logic [TICK_W-1:0]     char_ticks,
    input  logic                  os_tick,
    output logic                  trig_req,
    output logic                  tmo_req,
    output logic                  ovr_pulse,
    output logic [IRQ_W-1:0]      irq_vec
);

    rx_ent_t       ent_in, head;
    logic [CW-1:0] count;
    logic          expired;
    logic          nonempty;

    assign ent_in   = '{brk: wr_brk, ferr: wr_ferr, ch: wr_char};
    assign nonempty = (count != '0);

    hsu_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .ent_in   (ent_in),
        .pop_req  (rd_en),
        .head     (head),
        .count    (count),
        .ovr      (ovr_pulse)
    );

    hsu_rx_thresh #(.DEPTH(DEPTH)) u_thresh (
        .code  (trig_code),
        .count (count),
        .trig  (trig_req)
    );

    hsu_rx_idle_timer #(.TICK_W(TICK_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wr_valid || rd_en),
        .nonempty   (nonempty),
        .tick       (os_tick),
        .char_ticks (char_ticks),
        .code       (tmo_code),
        .expired    (expired)
    );

    always_comb begin
        tmo_req    = expired && !trig_req;
        rd_word    = nonempty ? {head.brk, head.ferr, 1'b0, head.ch} : EMPTY_WORD;
        level_word = {tx_level, RXL_W'(count)};
        irq_vec           = '0;
        irq_vec[IRQ_TRIG] = trig_req;
        irq_vec[IRQ_TMO]  = tmo_req;
        irq_vec[IRQ_OVR]  = ovr_pulse;
    end

endmodule

// File: rtl/hsu_rx_buffer_chk.sv
module hsu_rx_buffer_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        rd_en,
    input logic [10:0] rd_word,
    input logic [15:0] level_word,
    input logic        trig_req,
    input logic        tmo_req,
    input logic        ovr_pulse,
    input logic [6:0]  irq_vec
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_word[7:0] <= 8'(DEPTH)); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !rd_en) |=> $stable(level_word[7:0])); // R1

    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (level_word[7:0] == 8'd0) |-> (rd_word == 11'h100)); // R3

    AST_TRIG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        trig_req |-> (level_word[7:0] != 8'd0)); // R5

    AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req |-> (level_word[7:0] != 8'd0 && !trig_req)); // R7

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(wr_valid && !rd_en && level_word[7:0] == 8'(DEPTH))); // R8

    AST_IRQ_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec == {1'b0, ovr_pulse, 2'b00, tmo_req, trig_req, 1'b0}); // R9

endmodule

bind hsu_rx_buffer hsu_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .rd_en      (rd_en),
    .rd_word    (rd_word),
    .level_word (level_word),
    .trig_req   (trig_req),
    .tmo_req    (tmo_req),
    .ovr_pulse  (ovr_pulse),
    .irq_vec    (irq_vec)
);

// File: tb/hsu_rx_buffer_test.sv
module hsu_rx_buffer_test;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_valid = 0;
    logic [7:0]  wr_char = 0;
    logic        wr_ferr = 0;
    logic        wr_brk = 0;
    logic        rd_en = 0;
    logic [10:0] rd_word;
    logic [7:0]  tx_level = 0;
    logic [15:0] level_word;
    logic [2:0]  trig_code = 3'd2;
    logic [1:0]  tmo_code = 2'd0;
    logic [15:0] char_ticks = 16'd4;
    logic        os_tick = 0;
    logic        trig_req, tmo_req, ovr_pulse;
    logic [6:0]  irq_vec;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hsu_rx_buffer uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_char(wr_char),
        .wr_ferr(wr_ferr), .wr_brk(wr_brk), .rd_en(rd_en), .rd_word(rd_word),
        .tx_level(tx_level), .level_word(level_word), .trig_code(trig_code),
        .tmo_code(tmo_code), .char_ticks(char_ticks), .os_tick(os_tick),
        .trig_req(trig_req), .tmo_req(tmo_req), .ovr_pulse(ovr_pulse),
        .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input logic fe, input logic bk);
        @(negedge clk);
        wr_valid = 1; wr_char = c; wr_ferr = fe; wr_brk = bk;
        @(negedge clk);
        wr_valid = 0; wr_ferr = 0; wr_brk = 0;
    endtask

    task automatic pop(output logic [10:0] w);
        @(negedge clk);
        w = rd_word;
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic drain();
        logic [10:0] w;
        while (level_word[7:0] != 0) pop(w);
    endtask

    function automatic int thr_of(input int c);
        case (c)
            0: return 1;
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            default: return 48;
        endcase
    endfunction

    task automatic t_reset();
        chk("R10 count", 32'(level_word[7:0]), 0);
        chk("R10 rd_word", 32'(rd_word), 32'h100);
        chk("R10 req", {29'd0, trig_req, tmo_req, ovr_pulse}, 0);
        chk("R10 irq", 32'(irq_vec), 0);
    endtask

    task automatic t_flags();
        logic [10:0] w;
        push(8'h41, 1, 0);
        push(8'h42, 0, 1);
        push(8'h43, 1, 1);
        chk("R1 count3", 32'(level_word[7:0]), 3);
        pop(w); chk("R2 ferr word", 32'(w), 32'h241);
        pop(w); chk("R2 brk word", 32'(w), 32'h442);
        pop(w); chk("R2 both word", 32'(w), 32'h643);
        chk("R1 count0", 32'(level_word[7:0]), 0);
    endtask

    task automatic t_empty_read();
        logic [10:0] w;
        pop(w);
        chk("R3 empty word", 32'(w), 32'h100);
        chk("R3 count stays", 32'(level_word[7:0]), 0);
        push(8'h5C, 0, 0);
        pop(w);
        chk("R3 pointer unmoved", 32'(w), 32'h05C);
    endtask

    task automatic t_tx_level();
        tx_level = 8'h5A; #1;
        chk("R4 tx byte", 32'(level_word[15:8]), 32'h5A);
        tx_level = 8'hC3; #1;
        chk("R4 tx byte2", 32'(level_word[15:8]), 32'hC3);
        tx_level = 0;
    endtask

    task automatic t_trigger();
        for (int k = 1; k <= 48; k++) begin
            push(8'(k), 0, 0);
            for (int c = 0; c < 8; c++) begin
                trig_code = 3'(c); #1;
                chk("R5 trig", 32'(trig_req), 32'(k >= thr_of(c)));
                chk("R9 trig bit", 32'(irq_vec[1]), 32'(k >= thr_of(c)));
            end
        end
        trig_code = 3'd2;
        drain();
    endtask

    task automatic t_overrun();
        logic [10:0] w;
        for (int i = 0; i < 64; i++) push(8'(i), 0, 0);
        chk("R1 full count", 32'(level_word[7:0]), 64);
        chk("R8 no ovr yet", 32'(ovr_pulse), 0);
        push(8'hEE, 0, 0);
        chk("R8 ovr pulse", 32'(ovr_pulse), 1);
        chk("R9 irq ovr+trig", 32'(irq_vec), 32'h22);
        chk("R8 count held", 32'(level_word[7:0]), 64);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(ovr_pulse), 0);
        @(negedge clk);
        w = rd_word;
        rd_en = 1; wr_valid = 1; wr_char = 8'hAB;
        @(negedge clk);
        rd_en = 0; wr_valid = 0;
        chk("R8 simul read word", 32'(w), 32'h000);
        chk("R8 simul no ovr", 32'(ovr_pulse), 0);
        chk("R8 simul count", 32'(level_word[7:0]), 64);
        for (int i = 1; i < 64; i++) begin
            pop(w);
            chk("R1 order", 32'(w), 32'(i));
        end
        pop(w);
        chk("R8 simul write kept", 32'(w), 32'h0AB);
        chk("R1 drained", 32'(level_word[7:0]), 0);
    endtask

    task automatic t_timeout(input logic [15:0] ticks, input logic [1:0] code);
        char_ticks = ticks; tmo_code = code;
        os_tick = 0;
        push(8'h11, 0, 0);
        os_tick = 1;
        repeat (12) @(negedge clk);
        chk("R6 not yet expired", 32'(tmo_req), 0);
        repeat (6) @(negedge clk);
        chk("R6 expired", 32'(tmo_req), 1);
        chk("R9 irq tmo", 32'(irq_vec), 32'h04);
        os_tick = 0;
    endtask

    task automatic t_timeout_disabled();
        tmo_code = 0; os_tick = 1;
        repeat (40) @(negedge clk);
        chk("R6 disabled", 32'(tmo_req), 0);
        os_tick = 0;
    endtask

    task automatic t_read_restart();
        logic [10:0] w;
        drain();
        char_ticks = 4; tmo_code = 1;
        push(8'h21, 0, 0);
        push(8'h22, 0, 0);
        os_tick = 1;
        repeat (12) @(negedge clk);
        chk("R7 before read", 32'(tmo_req), 0);
        pop(w);
        repeat (12) @(negedge clk);
        chk("R7 restarted by read", 32'(tmo_req), 0);
        repeat (6) @(negedge clk);
        chk("R7 expired after read", 32'(tmo_req), 1);
        trig_code = 3'd0; #1;
        chk("R7 masked by trig", 32'(tmo_req), 0);
        trig_code = 3'd2;
        pop(w);
        repeat (20) @(negedge clk);
        chk("R7 empty no tmo", 32'(tmo_req), 0);
        os_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_empty_read();
        t_tx_level();
        t_trigger();
        t_overrun();
        t_timeout(16'd4, 2'd1);
        t_timeout(16'd2, 2'd2);
        t_timeout(16'd0, 2'd3);
        t_timeout_disabled();
        t_read_restart();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule